// File: doc/BRIEF.md
# Tagged Fully-Associative Micro Translation Buffer

This block is a small translation cache that sits beside one access port of a core. Each lookup presents a 48-bit virtual address, the current address-space identifier (ASID), the virtual machine identifier (VMID) and the execution state. One clock later the block returns hit or miss, a 40-bit physical address and the attribute byte stored with the mapping. All ten entries are compared in parallel. The lowest-index match wins, and a flag reports when more than one entry matched.

On a miss, an external walker installs a mapping through the fill port. The fill carries the virtual and physical page numbers, the tags, a global flag and a page size of 4KB or 64KB. The victim slot is the lowest invalid entry. When no entry is invalid, a round-robin pointer picks the victim. Maintenance inputs drop every entry, entries of one ASID, entries of one VMID, or entries covering one virtual page. Each of these acts within one cycle.

Top module: `utlb_top`

## Requirements
- R1: The buffer holds 10 entries, all compared on each lookup. `rsp_valid` is high exactly in the cycle after `lk_req`, and `rsp_hit` reports whether a valid entry matched.
- R2: A 4KB entry matches on VA[47:12] and returns PA = {stored PPN[39:12], VA[11:0]}. A 64KB entry (`fill_big`=1) matches on VA[47:16] and returns PA = {stored PPN[39:16], VA[15:0]}.
- R3: A non-global entry needs an ASID match. With `lk_wide`=1 all 16 bits are compared. With `lk_wide`=0 only bits [7:0] are compared.
- R4: An entry filled with `fill_glob`=1 matches whatever the lookup ASID is.
- R5: A hit also requires the stored VMID to equal `lk_vmid`.
- R6: A fill with `fill_big`=1 and `fill_wide`=0 writes nothing, and `fill_rej` is high in the following cycle. Any other fill leaves `fill_rej` low.
- R7: A fill goes to the lowest-index invalid entry. If all entries are valid, it goes to the entry at a round-robin pointer. The pointer resets to 0, advances only on such a replacement, and wraps after entry 9.
- R8: A lookup in the same cycle as a fill sees the contents from before the fill.
- R9: `inv_all` clears every entry in one cycle. An entry written by a fill in the same cycle as any invalidation stays valid. The victim is chosen from the valid bits before the invalidation.
- R10: `inv_by_asid` clears non-global entries whose 16-bit ASID equals `inv_asid`. Global entries are kept.
- R11: `inv_by_vmid` clears entries whose VMID equals `inv_vmid`.
- R12: `inv_by_va` clears every entry whose page, at that entry's own size, contains `inv_vpn`, whatever the entry's tags.
- R13: When several entries match, the lowest index supplies PA and attributes and `rsp_multi` is 1. A miss returns PA 0, attributes 0 and `rsp_multi` 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_req | input | 1 | Lookup request |
| lk_va | input | 48 | Lookup virtual address |
| lk_asid | input | 16 | Current ASID |
| lk_vmid | input | 16 | Current VMID |
| lk_wide | input | 1 | 1: 64-bit state, 0: 32-bit state |
| rsp_valid | output | 1 | Lookup result valid |
| rsp_hit | output | 1 | Lookup hit |
| rsp_pa | output | 40 | Physical address |
| rsp_attr | output | 8 | Stored attributes |
| rsp_multi | output | 1 | More than one entry matched |
| fill_req | input | 1 | Install a mapping |
| fill_vpn | input | 36 | Virtual page number, VA[47:12] |
| fill_ppn | input | 28 | Physical page number, PA[39:12] |
| fill_asid | input | 16 | ASID tag |
| fill_vmid | input | 16 | VMID tag |
| fill_glob | input | 1 | Global mapping |
| fill_big | input | 1 | 1: 64KB page, 0: 4KB page |
| fill_wide | input | 1 | Execution state of the fill |
| fill_attr | input | 8 | Attribute bits |
| fill_rej | output | 1 | Previous cycle's fill was rejected |
| inv_all | input | 1 | Invalidate all entries |
| inv_by_asid | input | 1 | Invalidate by ASID |
| inv_by_vmid | input | 1 | Invalidate by VMID |
| inv_by_va | input | 1 | Invalidate by virtual page |
| inv_asid | input | 16 | ASID operand |
| inv_vmid | input | 16 | VMID operand |
| inv_vpn | input | 36 | Virtual page operand, VA[47:12] |

## Verification
A fill can land in the same cycle as a lookup, and in the same cycle as an invalidation. The bench drives a fill and a lookup of the same page on one edge. The scoreboard expects a miss for that lookup and a hit for the next one. The bench also drives a fill together with invalidate-all. It then expects a hit on the new page, misses on every older page, and a victim slot chosen from the valid bits before the clear.

// File: rtl/utlb_pkg.sv
package utlb_pkg;
  localparam int VA_W     = 48;
  localparam int PA_W     = 40;
  localparam int ASID_W   = 16;
  localparam int ASID_NW  = 8;
  localparam int VMID_W   = 16;
  localparam int ATTR_W   = 8;
  localparam int SMALL_SH = 12;
  localparam int LARGE_SH = 16;
  localparam int VPN_W    = VA_W - SMALL_SH;
  localparam int PPN_W    = PA_W - SMALL_SH;
  localparam int GRAN_D   = LARGE_SH - SMALL_SH;

  typedef struct packed {
    logic [VPN_W-1:0]  vpn;
    logic [PPN_W-1:0]  ppn;
    logic [ASID_W-1:0] asid;
    logic [VMID_W-1:0] vmid;
    logic              glob;
    logic              big;
    logic [ATTR_W-1:0] attr;
  } utlb_ent_t;

  // Page compare at the stored entry's own size.
  function automatic logic page_hit(input logic [VPN_W-1:0] stored,
                                    input logic big,
                                    input logic [VPN_W-1:0] probe);
    logic hi_eq;
    logic lo_eq;
    hi_eq = (stored[VPN_W-1:GRAN_D] == probe[VPN_W-1:GRAN_D]);
    lo_eq = (stored[GRAN_D-1:0] == probe[GRAN_D-1:0]);
    return hi_eq && (big || lo_eq);
  endfunction
endpackage

// File: rtl/utlb_entry.sv
module utlb_entry
  import utlb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  utlb_ent_t         wr_ent,
  input  logic [VPN_W-1:0]  lk_vpn,
  input  logic [ASID_W-1:0] lk_asid,
  input  logic [VMID_W-1:0] lk_vmid,
  input  logic              lk_wide,
  input  logic              inv_all,
  input  logic              inv_by_asid,
  input  logic              inv_by_vmid,
  input  logic              inv_by_va,
  input  logic [ASID_W-1:0] inv_asid,
  input  logic [VMID_W-1:0] inv_vmid,
  input  logic [VPN_W-1:0]  inv_vpn,
  output logic              valid_o,
  output logic              hit_o,
  output logic [PPN_W-1:0]  ppn_o,
  output logic              big_o,
  output logic [ATTR_W-1:0] attr_o
);
  logic      valid_q, valid_d;
  utlb_ent_t ent_q;
  logic      kill;
  logic      asid_ok;

  always_comb begin
    kill = inv_all
         | (inv_by_asid & ~ent_q.glob & (ent_q.asid == inv_asid))
         | (inv_by_vmid & (ent_q.vmid == inv_vmid))
         | (inv_by_va & page_hit(ent_q.vpn, ent_q.big, inv_vpn));
    if (wr_en) valid_d = 1'b1;
    else       valid_d = valid_q & ~kill;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= 1'b0;
    else        valid_q <= valid_d;
  end

  always_ff @(posedge clk) begin
    if (wr_en) ent_q <= wr_ent;
  end

  always_comb begin
    if (lk_wide) asid_ok = (ent_q.asid == lk_asid);
    else         asid_ok = (ent_q.asid[ASID_NW-1:0] == lk_asid[ASID_NW-1:0]);
    hit_o = valid_q & page_hit(ent_q.vpn, ent_q.big, lk_vpn)
          & (ent_q.glob | asid_ok) & (ent_q.vmid == lk_vmid);
  end

  assign valid_o = valid_q;
  assign ppn_o   = ent_q.ppn;
  assign big_o   = ent_q.big;
  assign attr_o  = ent_q.attr;

  a_r9_fill_survives: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> valid_o);
  a_r10_global_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && ent_q.glob && inv_by_asid && !inv_all && !inv_by_vmid && !inv_by_va)
      |=> valid_o);
  a_r1_hit_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
    hit_o |-> valid_o);
endmodule

// File: rtl/utlb_victim.sv
module utlb_victim #(
  parameter int N = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         fill_ok,
  input  logic [N-1:0] valid_vec,
  output logic [N-1:0] wr_en_o
);
  localparam int PTR_W = (N > 1) ? $clog2(N) : 1;
  localparam logic [PTR_W-1:0] LAST = PTR_W'(N - 1);

  logic [PTR_W-1:0] rr_q, rr_d, pick;
  logic             found, rr_en;
  logic [N-1:0]     one;

  always_comb begin
    pick  = rr_q;
    found = 1'b0;
    for (int i = N - 1; i >= 0; i--) begin
      if (!valid_vec[i]) begin
        pick  = PTR_W'(i);
        found = 1'b1;
      end
    end
    one     = {{(N-1){1'b0}}, 1'b1};
    wr_en_o = fill_ok ? (one << pick) : '0;
    rr_en   = fill_ok & ~found;
    rr_d    = (rr_q == LAST) ? '0 : rr_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rr_q <= '0;
    else if (rr_en) rr_q <= rr_d;
  end

  a_r7_one_victim: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wr_en_o));
  a_r7_ptr_range: assert property (@(posedge clk) disable iff (!rst_n)
    rr_q <= LAST);
  a_r7_ptr_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !(fill_ok && (&valid_vec)) |=> $stable(rr_q));
endmodule

// File: rtl/utlb_resp.sv
module utlb_resp
  import utlb_pkg::*;
#(
  parameter int N = 10
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         lk_req,
  input  logic [LARGE_SH-1:0]          lk_off,
  input  logic [N-1:0]                 hit_vec,
  input  logic [N-1:0][PPN_W-1:0]      ppn_vec,
  input  logic [N-1:0]                 big_vec,
  input  logic [N-1:0][ATTR_W-1:0]     attr_vec,
  output logic                         rsp_valid,
  output logic                         rsp_hit,
  output logic [PA_W-1:0]              rsp_pa,
  output logic [ATTR_W-1:0]            rsp_attr,
  output logic                         rsp_multi
);
  localparam int SEL_W = (N > 1) ? $clog2(N) : 1;

  logic [SEL_W-1:0]  sel;
  logic              any, multi;
  logic [PA_W-1:0]   pa_d;
  logic [ATTR_W-1:0] attr_d;
  logic [PPN_W-1:0]  ppn_s;

  always_comb begin
    sel   = '0;
    any   = 1'b0;
    multi = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (hit_vec[i]) begin
        if (any) multi = 1'b1;
        else     sel   = SEL_W'(i);
        any = 1'b1;
      end
    end
    ppn_s = ppn_vec[sel];
    if (!any)              pa_d = '0;
    else if (big_vec[sel]) pa_d = {ppn_s[PPN_W-1:GRAN_D], lk_off};
    else                   pa_d = {ppn_s, lk_off[SMALL_SH-1:0]};
    attr_d = any ? attr_vec[sel] : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_multi <= 1'b0;
      rsp_pa    <= '0;
      rsp_attr  <= '0;
    end else begin
      rsp_valid <= lk_req;
      rsp_hit   <= lk_req & any;
      rsp_multi <= lk_req & multi;
      rsp_pa    <= lk_req ? pa_d : '0;
      rsp_attr  <= lk_req ? attr_d : '0;
    end
  end

  a_r1_rsp_after_req: assert property (@(posedge clk) disable iff (!rst_n)
    lk_req |=> rsp_valid);
  a_r1_no_rsp_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_req |=> !rsp_valid && !rsp_hit);
  a_r13_multi_is_hit: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_multi |-> rsp_hit);
endmodule

// File: rtl/utlb_top.sv
module utlb_top
  import utlb_pkg::*;
#(
  parameter int ENTRIES = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lk_req,
  input  logic [VA_W-1:0]   lk_va,
  input  logic [ASID_W-1:0] lk_asid,
  input  logic [VMID_W-1:0] lk_vmid,
  input  logic              lk_wide,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic [PA_W-1:0]   rsp_pa,
  output logic [ATTR_W-1:0] rsp_attr,
  output logic              rsp_multi,
  input  logic              fill_req,
  input  logic [VPN_W-1:0]  fill_vpn,
  input  logic [PPN_W-1:0]  fill_ppn,
  input  logic [ASID_W-1:0] fill_asid,
  input  logic [VMID_W-1:0] fill_vmid,
  input  logic              fill_glob,
  input  logic              fill_big,
  input  logic              fill_wide,
  input  logic [ATTR_W-1:0] fill_attr,
  output logic              fill_rej,
  input  logic              inv_all,
  input  logic              inv_by_asid,
  input  logic              inv_by_vmid,
  input  logic              inv_by_va,
  input  logic [ASID_W-1:0] inv_asid,
  input  logic [VMID_W-1:0] inv_vmid,
  input  logic [VPN_W-1:0]  inv_vpn
);
  logic                          fill_ok, rej_d;
  utlb_ent_t                     wr_ent;
  logic [ENTRIES-1:0]            valid_vec, hit_vec, big_vec, wr_en;
  logic [ENTRIES-1:0][PPN_W-1:0] ppn_vec;
  logic [ENTRIES-1:0][ATTR_W-1:0] attr_vec;
  logic [VPN_W-1:0]              lk_vpn;
  logic                          any_inv;

  always_comb begin
    fill_ok     = fill_req & ~(fill_big & ~fill_wide);
    rej_d       = fill_req & ~fill_ok;
    lk_vpn      = lk_va[VA_W-1:SMALL_SH];
    any_inv     = inv_all | inv_by_asid | inv_by_vmid | inv_by_va;
    wr_ent.vpn  = fill_vpn;
    wr_ent.ppn  = fill_ppn;
    wr_ent.asid = fill_asid;
    wr_ent.vmid = fill_vmid;
    wr_ent.glob = fill_glob;
    wr_ent.big  = fill_big;
    wr_ent.attr = fill_attr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fill_rej <= 1'b0;
    else        fill_rej <= rej_d;
  end

  utlb_victim #(.N(ENTRIES)) u_victim (
    .clk       (clk),
    .rst_n     (rst_n),
    .fill_ok   (fill_ok),
    .valid_vec (valid_vec),
    .wr_en_o   (wr_en)
  );

  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    utlb_entry u_ent (
      .clk         (clk),
      .rst_n       (rst_n),
      .wr_en       (wr_en[g]),
      .wr_ent      (wr_ent),
      .lk_vpn      (lk_vpn),
      .lk_asid     (lk_asid),
      .lk_vmid     (lk_vmid),
      .lk_wide     (lk_wide),
      .inv_all     (inv_all),
      .inv_by_asid (inv_by_asid),
      .inv_by_vmid (inv_by_vmid),
      .inv_by_va   (inv_by_va),
      .inv_asid    (inv_asid),
      .inv_vmid    (inv_vmid),
      .inv_vpn     (inv_vpn),
      .valid_o     (valid_vec[g]),
      .hit_o       (hit_vec[g]),
      .ppn_o       (ppn_vec[g]),
      .big_o       (big_vec[g]),
      .attr_o      (attr_vec[g])
    );
  end

  utlb_resp #(.N(ENTRIES)) u_resp (
    .clk       (clk),
    .rst_n     (rst_n),
    .lk_req    (lk_req),
    .lk_off    (lk_va[LARGE_SH-1:0]),
    .hit_vec   (hit_vec),
    .ppn_vec   (ppn_vec),
    .big_vec   (big_vec),
    .attr_vec  (attr_vec),
    .rsp_valid (rsp_valid),
    .rsp_hit   (rsp_hit),
    .rsp_pa    (rsp_pa),
    .rsp_attr  (rsp_attr),
    .rsp_multi (rsp_multi)
  );

  a_r6_reject_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_req && fill_big && !fill_wide) |=> fill_rej);
  a_r6_reject_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_req && fill_big && !fill_wide && !any_inv) |=> valid_vec == $past(valid_vec));
  a_r9_clear_all: assert property (@(posedge clk) disable iff (!rst_n)
    (inv_all && !fill_req) |=> valid_vec == '0);
  a_r6_accept_no_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_req && !(fill_big && !fill_wide)) |=> !fill_rej);
endmodule

// File: tb/utlb_top_tb.sv
module utlb_top_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        lk_req = 1'b0;
  logic [47:0] lk_va = '0;
  logic [15:0] lk_asid = '0, lk_vmid = '0;
  logic        lk_wide = 1'b0;
  logic        rsp_valid, rsp_hit, rsp_multi, fill_rej;
  logic [39:0] rsp_pa;
  logic [7:0]  rsp_attr;
  logic        fill_req = 1'b0;
  logic [35:0] fill_vpn = '0;
  logic [27:0] fill_ppn = '0;
  logic [15:0] fill_asid = '0, fill_vmid = '0;
  logic        fill_glob = 1'b0, fill_big = 1'b0, fill_wide = 1'b0;
  logic [7:0]  fill_attr = '0;
  logic        inv_all = 1'b0, inv_by_asid = 1'b0, inv_by_vmid = 1'b0, inv_by_va = 1'b0;
  logic [15:0] inv_asid = '0, inv_vmid = '0;
  logic [35:0] inv_vpn = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  utlb_top u_dut (
    .clk(clk), .rst_n(rst_n),
    .lk_req(lk_req), .lk_va(lk_va), .lk_asid(lk_asid), .lk_vmid(lk_vmid), .lk_wide(lk_wide),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_pa(rsp_pa), .rsp_attr(rsp_attr),
    .rsp_multi(rsp_multi),
    .fill_req(fill_req), .fill_vpn(fill_vpn), .fill_ppn(fill_ppn), .fill_asid(fill_asid),
    .fill_vmid(fill_vmid), .fill_glob(fill_glob), .fill_big(fill_big), .fill_wide(fill_wide),
    .fill_attr(fill_attr), .fill_rej(fill_rej),
    .inv_all(inv_all), .inv_by_asid(inv_by_asid), .inv_by_vmid(inv_by_vmid),
    .inv_by_va(inv_by_va), .inv_asid(inv_asid), .inv_vmid(inv_vmid), .inv_vpn(inv_vpn)
  );

  typedef struct {
    logic        hit;
    logic [39:0] pa;
    logic [7:0]  attr;
    logic        multi;
    string       tag;
  } exp_t;

  exp_t exp_q[$];
  int   n_chk = 0;
  int   n_bad = 0;
  bit   done = 0;

  task automatic check(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Monitor: pops one expected item per response.
  always @(negedge clk) begin
    if (rst_n && rsp_valid && !done) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R1 unexpected response", {63'd0, rsp_hit}, 64'd0);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        check(rsp_hit == e.hit && rsp_pa == e.pa && rsp_attr == e.attr && rsp_multi == e.multi,
              e.tag, {15'd0, rsp_multi, rsp_hit, rsp_attr, rsp_pa},
              {15'd0, e.multi, e.hit, e.attr, e.pa});
      end
    end
  end

  task automatic push(input logic h, input logic [39:0] pa, input logic [7:0] at,
                      input logic m, input string tag);
    exp_t e;
    e.hit = h; e.pa = pa; e.attr = at; e.multi = m; e.tag = tag;
    exp_q.push_back(e);
  endtask

  task automatic lookup(input logic [47:0] va, input logic [15:0] asid, input logic [15:0] vmid,
                        input logic wide, input logic h, input logic [39:0] pa,
                        input logic [7:0] at, input logic m, input string tag);
    @(negedge clk);
    lk_req = 1'b1; lk_va = va; lk_asid = asid; lk_vmid = vmid; lk_wide = wide;
    push(h, pa, at, m, tag);
    @(negedge clk);
    lk_req = 1'b0;
  endtask

  task automatic set_fill(input logic [47:0] va, input logic [39:0] pa, input logic [15:0] asid,
                          input logic [15:0] vmid, input logic g, input logic big,
                          input logic wide, input logic [7:0] at);
    fill_req = 1'b1; fill_vpn = va[47:12]; fill_ppn = pa[39:12];
    fill_asid = asid; fill_vmid = vmid; fill_glob = g; fill_big = big;
    fill_wide = wide; fill_attr = at;
  endtask

  task automatic fill(input logic [47:0] va, input logic [39:0] pa, input logic [15:0] asid,
                      input logic [15:0] vmid, input logic g, input logic big,
                      input logic wide, input logic [7:0] at);
    @(negedge clk);
    set_fill(va, pa, asid, vmid, g, big, wide, at);
    @(negedge clk);
    fill_req = 1'b0;
    check(fill_rej == (big && !wide), "R6 fill_rej", {63'd0, fill_rej}, {63'd0, big && !wide});
  endtask

  task automatic inval(input logic a, input logic ba, input logic bv, input logic bp,
                       input logic [15:0] asid, input logic [15:0] vmid, input logic [47:0] va);
    @(negedge clk);
    inv_all = a; inv_by_asid = ba; inv_by_vmid = bv; inv_by_va = bp;
    inv_asid = asid; inv_vmid = vmid; inv_vpn = va[47:12];
    @(negedge clk);
    inv_all = 0; inv_by_asid = 0; inv_by_vmid = 0; inv_by_va = 0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    check(1'b0, "watchdog expired", 64'd0, 64'd1);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    check(!rsp_valid && !rsp_hit && !fill_rej && !rsp_multi, "R1 reset state",
          {60'd0, rsp_valid, rsp_hit, fill_rej, rsp_multi}, 64'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // E0 at entry 0
    fill(48'h0000_1234_5000, 40'h12_3456_7000, 16'h0005, 16'd1, 0, 0, 1, 8'h11);
    lookup(48'h0000_1234_5ABC, 16'h0005, 16'd1, 1, 1, 40'h12_3456_7ABC, 8'h11, 0, "R1 R2 4KB hit");
    lookup(48'h0000_1234_5ABC, 16'h0006, 16'd1, 1, 0, 40'h0, 8'h0, 0, "R3 ASID mismatch miss");
    lookup(48'h0000_1234_5ABC, 16'h0005, 16'd2, 1, 0, 40'h0, 8'h0, 0, "R5 VMID mismatch miss");
    // E1 at entry 1, 32-bit state
    fill(48'h0000_2000_0000, 40'h00_4000_0000, 16'h0107, 16'd3, 0, 0, 0, 8'h22);
    lookup(48'h0000_2000_0010, 16'hAB07, 16'd3, 0, 1, 40'h00_4000_0010, 8'h22, 0, "R3 narrow ASID hit");
    lookup(48'h0000_2000_0010, 16'hAB07, 16'd3, 1, 0, 40'h0, 8'h0, 0, "R3 wide ASID miss");
    // E2 global at entry 2
    fill(48'h0000_0000_A000, 40'h00_0000_B000, 16'h0005, 16'd1, 1, 0, 1, 8'h33);
    lookup(48'h0000_0000_A004, 16'h0033, 16'd1, 1, 1, 40'h00_0000_B004, 8'h33, 0, "R4 global hit");
    lookup(48'h0000_0000_A004, 16'h0033, 16'd4, 1, 0, 40'h0, 8'h0, 0, "R5 global VMID miss");
    // E3 64KB at entry 3
    fill(48'h0000_7777_0000, 40'h55_5555_0000, 16'h0005, 16'd1, 0, 1, 1, 8'h44);
    lookup(48'h0000_7777_F123, 16'h0005, 16'd1, 1, 1, 40'h55_5555_F123, 8'h44, 0, "R2 64KB hit");
    lookup(48'h0000_7778_0123, 16'h0005, 16'd1, 1, 0, 40'h0, 8'h0, 0, "R2 64KB next page miss");
    // rejected 64KB in 32-bit state
    fill(48'h0000_9999_0000, 40'h66_6666_0000, 16'h0005, 16'd1, 0, 1, 0, 8'h99);
    lookup(48'h0000_9999_0000, 16'h0005, 16'd1, 0, 0, 40'h0, 8'h0, 0, "R6 rejected fill absent");
    // E4 4KB overlapping E3, at entry 4
    fill(48'h0000_7777_3000, 40'h00_0AAA_A000, 16'h0005, 16'd1, 0, 0, 1, 8'h55);
    lookup(48'h0000_7777_3456, 16'h0005, 16'd1, 1, 1, 40'h55_5555_3456, 8'h44, 1, "R13 multi lowest wins");
    // invalidate by VA covers both E3 and E4
    inval(0, 0, 0, 1, 16'h0, 16'h0, 48'h0000_7777_3FFF);
    lookup(48'h0000_7777_3456, 16'h0005, 16'd1, 1, 0, 40'h0, 8'h0, 0, "R12 VA inval 4KB+64KB");
    lookup(48'h0000_7777_F123, 16'h0005, 16'd1, 1, 0, 40'h0, 8'h0, 0, "R12 VA inval 64KB page");
    // invalidate by ASID 5
    inval(0, 1, 0, 0, 16'h0005, 16'h0, 48'h0);
    lookup(48'h0000_1234_5ABC, 16'h0005, 16'd1, 1, 0, 40'h0, 8'h0, 0, "R10 ASID inval clears");
    lookup(48'h0000_0000_A004, 16'h0005, 16'd1, 1, 1, 40'h00_0000_B004, 8'h33, 0, "R10 global kept");
    // invalidate by VMID 3
    inval(0, 0, 1, 0, 16'h0, 16'd3, 48'h0);
    lookup(48'h0000_2000_0010, 16'hAB07, 16'd3, 0, 0, 40'h0, 8'h0, 0, "R11 VMID inval clears");
    lookup(48'h0000_0000_A004, 16'h0005, 16'd1, 1, 1, 40'h00_0000_B004, 8'h33, 0, "R11 other VMID kept");
    // fill and lookup in one cycle
    @(negedge clk);
    set_fill(48'h0000_3000_0000, 40'h00_6000_0000, 16'h0007, 16'd2, 0, 0, 1, 8'h66);
    lk_req = 1'b1; lk_va = 48'h0000_3000_0000; lk_asid = 16'h0007; lk_vmid = 16'd2; lk_wide = 1'b1;
    push(0, 40'h0, 8'h0, 0, "R8 same-cycle lookup sees old contents");
    @(negedge clk);
    fill_req = 1'b0; lk_req = 1'b0;
    lookup(48'h0000_3000_0000, 16'h0007, 16'd2, 1, 1, 40'h00_6000_0000, 8'h66, 0, "R8 hit after fill");
    // fill together with invalidate-all
    @(negedge clk);
    set_fill(48'h0000_4000_0000, 40'h00_7000_0000, 16'h0007, 16'd2, 0, 0, 1, 8'h77);
    inv_all = 1'b1;
    @(negedge clk);
    fill_req = 1'b0; inv_all = 1'b0;
    lookup(48'h0000_4000_0000, 16'h0007, 16'd2, 1, 1, 40'h00_7000_0000, 8'h77, 0, "R9 fill survives inv_all");
    lookup(48'h0000_0000_A004, 16'h0005, 16'd1, 1, 0, 40'h0, 8'h0, 0, "R9 inv_all clears global");
    lookup(48'h0000_3000_0000, 16'h0007, 16'd2, 1, 0, 40'h0, 8'h0, 0, "R9 inv_all clears entry 0");
    // replacement order
    inval(1, 0, 0, 0, 16'h0, 16'h0, 48'h0);
    for (int k = 0; k < 12; k++)
      fill(48'h0000_0010_0000 + (48'(k) << 12), 40'h00_0800_0000 + (40'(k) << 12),
           16'h0001, 16'd1, 0, 0, 1, 8'(k));
    lookup(48'h0000_0010_0000, 16'h0001, 16'd1, 1, 0, 40'h0, 8'h0, 0, "R7 rr replaced entry 0");
    lookup(48'h0000_0010_1000, 16'h0001, 16'd1, 1, 0, 40'h0, 8'h0, 0, "R7 rr replaced entry 1");
    lookup(48'h0000_0010_2000, 16'h0001, 16'd1, 1, 1, 40'h00_0800_2000, 8'd2, 0, "R7 entry 2 kept");
    lookup(48'h0000_0010_B000, 16'h0001, 16'd1, 1, 1, 40'h00_0800_B000, 8'd11, 0, "R7 new page present");
    // a free slot is used before the pointer
    inval(0, 0, 0, 1, 16'h0, 16'h0, 48'h0000_0010_5000);
    fill(48'h0000_0010_C000, 40'h00_0800_C000, 16'h0001, 16'd1, 0, 0, 1, 8'd12);
    fill(48'h0000_0010_D000, 40'h00_0800_D000, 16'h0001, 16'd1, 0, 0, 1, 8'd13);
    lookup(48'h0000_0010_2000, 16'h0001, 16'd1, 1, 0, 40'h0, 8'h0, 0, "R7 pointer replaced entry 2");
    lookup(48'h0000_0010_3000, 16'h0001, 16'd1, 1, 1, 40'h00_0800_3000, 8'd3, 0, "R7 entry 3 kept");
    lookup(48'h0000_0010_C000, 16'h0001, 16'd1, 1, 1, 40'h00_0800_C000, 8'd12, 0, "R7 free slot filled");

    repeat (3) @(negedge clk);
    check(exp_q.size() == 0, "R1 all responses seen", 64'(exp_q.size()), 64'd0);
    finish_run();
  end
endmodule